// File: doc/BRIEF.md
# Pipeline Hazard Stall and Flush Control

This block decides, every cycle, whether a five-stage integer pipeline has to pause its front end or discard an instruction. Branches and jumps are resolved in the decode stage, so a control instruction there needs its source operands earlier than an ordinary instruction would. Ordinary instructions get their operands by bypass from later stages, and only a load that has just reached execute forces them to wait. A control instruction waits for any producer still in execute, and for a load still in the memory stage.

When a wait is needed, three controls rise together. The program counter is frozen. The fetch/decode register keeps its instruction. The decode/execute register is filled with a bubble. When the decode stage signals a taken jump and no wait is needed, a fourth control discards the instruction fetched on the wrong path. All outputs depend only on the current stage contents. Reset holds them low.

Top module: `hazard_ctl`

## Requirements
- R1: While rst_n is low, all four outputs are 0.
- R2: When the execute-stage instruction is a load with ex_wen=1 and a nonzero ex_rd equal to a used decode source (rs1 with rs1_used=1 or rs2 with rs2_used=1), the stall outputs are 1.
- R3: pc_stall, if_stall and id_flush are always equal.
- R4: A decode-stage control instruction (id_ctrl=1) stalls when a non-load execute-stage instruction with ex_wen=1 and a nonzero ex_rd writes one of its used sources.
- R5: A decode-stage control instruction stalls when a load in the memory stage (mem_load=1) has a nonzero mem_rd equal to one of its used sources.
- R6: A non-control decode instruction does not stall on a non-load producer in execute.
- R7: A non-control decode instruction does not stall on a load in the memory stage.
- R8: A destination register of 0 in either stage never causes a stall.
- R9: A producer with ex_wen=0 never causes a stall, and a source whose used flag is 0 never causes a stall.
- R10: When jump is 1 and no stall is required, if_flush is 1. When jump is 0, if_flush is 0.
- R11: When a stall is required, if_flush is 0, even if jump is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the checker |
| rst_n | input | 1 | Active-low reset; forces outputs low |
| id_rs1 | input | AW | Decode-stage first source register |
| id_rs2 | input | AW | Decode-stage second source register |
| id_rs1_used | input | 1 | First source is read |
| id_rs2_used | input | 1 | Second source is read |
| id_ctrl | input | 1 | Decode instruction is a branch or jump |
| ex_rd | input | AW | Execute-stage destination register |
| ex_wen | input | 1 | Execute-stage register write enable |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | AW | Memory-stage destination register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| jump | input | 1 | Decode stage resolved a taken branch or jump |
| pc_stall | output | 1 | Hold the program counter |
| if_stall | output | 1 | Hold the fetch/decode register |
| id_flush | output | 1 | Load a bubble into the decode/execute register |
| if_flush | output | 1 | Discard the wrongly fetched instruction |

## Verification
The block holds no state, so any fault shows at the ports in the same cycle as the inputs that expose it. A missing stall lets a branch resolve on a stale register, which corrupts control flow with no way to recover. An extra stall only costs cycles. The bench therefore checks both directions for each producer kind and stage. It uses register numbers drawn from a small range, so matches, zero destinations and cleared enables occur often and in combination.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_rs1_used,
  input  logic          id_rs2_used,
  input  logic          id_ctrl,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_load,
  input  logic          jump,
  output logic          pc_stall,
  output logic          if_stall,
  output logic          id_flush,
  output logic          if_flush
);
  logic ex_live, mem_live, ex_match, mem_match, stall;

  assign ex_live  = ex_wen && (ex_rd != '0);
  assign mem_live = mem_load && (mem_rd != '0);

  assign ex_match  = ex_live && ((id_rs1_used && id_rs1 == ex_rd) ||
                                 (id_rs2_used && id_rs2 == ex_rd));
  assign mem_match = mem_live && ((id_rs1_used && id_rs1 == mem_rd) ||
                                  (id_rs2_used && id_rs2 == mem_rd));

  assign stall = rst_n && ((ex_match && (ex_load || id_ctrl)) ||
                           (mem_match && id_ctrl));

  assign pc_stall = stall;
  assign if_stall = stall;
  assign id_flush = stall;
  assign if_flush = rst_n && jump && !stall;
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] id_rs1,
  input logic [AW-1:0] id_rs2,
  input logic          id_rs1_used,
  input logic          id_rs2_used,
  input logic          id_ctrl,
  input logic [AW-1:0] ex_rd,
  input logic          ex_wen,
  input logic          ex_load,
  input logic [AW-1:0] mem_rd,
  input logic          mem_load,
  input logic          jump,
  input logic          pc_stall,
  input logic          if_stall,
  input logic          id_flush,
  input logic          if_flush
);
  logic load_hit;
  assign load_hit = ex_load && ex_wen && ex_rd != '0 &&
                    ((id_rs1_used && id_rs1 == ex_rd) || (id_rs2_used && id_rs2 == ex_rd));

  // R1
  always @(posedge clk)
    if (!rst_n) reset_quiet_chk: assert (!pc_stall && !if_stall && !id_flush && !if_flush);

  // R3
  stall_trio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_stall == if_stall && if_stall == id_flush);

  // R2
  load_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_hit |-> pc_stall);

  // R8
  zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == '0 && mem_rd == '0) |-> !pc_stall);

  // R9
  no_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_rs1_used && !id_rs2_used) |-> !pc_stall);

  // R10
  jump_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump && !pc_stall) |-> if_flush);

  // R11
  stall_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_stall |-> !if_flush);
endmodule

bind hazard_ctl hazard_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
  .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used), .id_ctrl(id_ctrl),
  .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load), .mem_rd(mem_rd),
  .mem_load(mem_load), .jump(jump), .pc_stall(pc_stall), .if_stall(if_stall),
  .id_flush(id_flush), .if_flush(if_flush)
);

// File: tb/hazard_ctl_tb.sv
module hazard_ctl_tb;
  localparam int PERIOD = 10;
  localparam int AW = 5;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] id_rs1 = 0, id_rs2 = 0, ex_rd = 0, mem_rd = 0;
  logic id_rs1_used = 0, id_rs2_used = 0, id_ctrl = 0, ex_wen = 0, ex_load = 0;
  logic mem_load = 0, jump = 0;
  logic pc_stall, if_stall, id_flush, if_flush;
  int compared = 0, mismatched = 0;

  always #(PERIOD/2) clk = ~clk;

  hazard_ctl #(.AW(AW)) u_dut (.*);

  function automatic bit model_stall();
    int srcs[$];
    bit need = 0;
    if (!rst_n) return 0;
    if (id_rs1_used) srcs.push_back(int'(id_rs1));
    if (id_rs2_used) srcs.push_back(int'(id_rs2));
    foreach (srcs[i]) begin
      if (srcs[i] == 0) continue;
      if (ex_wen && srcs[i] == int'(ex_rd) && (ex_load || id_ctrl)) need = 1;
      if (mem_load && srcs[i] == int'(mem_rd) && id_ctrl) need = 1;
    end
    return need;
  endfunction

  task automatic cmp(input string tag);
    bit s = model_stall();
    bit f = rst_n && jump && !s;
    compared++;
    if ({pc_stall, if_stall, id_flush, if_flush} !== {s, s, s, f}) begin
      mismatched++;
      $display("FAIL %s: got pc/if/id/iff=%b%b%b%b expected %b%b%b%b", tag,
               pc_stall, if_stall, id_flush, if_flush, s, s, s, f);
    end
  endtask

  task automatic drive(input int r1, input int r2, input bit u1, input bit u2, input bit c,
                       input int er, input bit ew, input bit el, input int mr, input bit ml,
                       input bit j);
    @(negedge clk);
    id_rs1 = AW'(r1); id_rs2 = AW'(r2); id_rs1_used = u1; id_rs2_used = u2; id_ctrl = c;
    ex_rd = AW'(er); ex_wen = ew; ex_load = el; mem_rd = AW'(mr); mem_load = ml; jump = j;
    #(PERIOD/4);
  endtask

  initial begin
    #(PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    drive(3, 4, 1, 1, 1, 3, 1, 1, 4, 1, 1); cmp("R1 outputs low in reset");
    @(negedge clk); rst_n = 1;
    drive(3, 4, 1, 0, 0, 3, 1, 1, 0, 0, 0); cmp("R2 load-use on rs1");
    drive(3, 4, 0, 1, 0, 4, 1, 1, 0, 0, 0); cmp("R2 load-use on rs2");
    drive(3, 4, 1, 1, 0, 4, 1, 1, 0, 0, 0); cmp("R3 stall trio equal");
    drive(5, 6, 1, 1, 1, 6, 1, 0, 0, 0, 1); cmp("R4 branch on ALU in EX");
    drive(5, 6, 1, 1, 1, 0, 0, 0, 5, 1, 0); cmp("R5 branch on load in MEM");
    drive(5, 6, 1, 1, 0, 6, 1, 0, 0, 0, 0); cmp("R6 ALU producer, no branch");
    drive(5, 6, 1, 1, 0, 0, 0, 0, 5, 1, 0); cmp("R7 MEM load, no branch");
    drive(0, 0, 1, 1, 1, 0, 1, 1, 0, 1, 1); cmp("R8 x0 destinations");
    drive(7, 8, 1, 1, 1, 7, 0, 1, 0, 0, 0); cmp("R9 write enable clear");
    drive(7, 8, 0, 0, 1, 7, 1, 1, 8, 1, 0); cmp("R9 sources unused");
    drive(1, 2, 1, 1, 1, 9, 1, 0, 9, 1, 1); cmp("R10 jump flush, no hazard");
    drive(1, 2, 1, 1, 1, 2, 1, 0, 0, 0, 1); cmp("R11 stall overrides jump");
    for (int k = 0; k < 4000; k++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom), 1'($urandom),
            1'($urandom), $urandom_range(0, 3), 1'($urandom), 1'($urandom),
            $urandom_range(0, 3), 1'($urandom), 1'($urandom));
      cmp("R2/R4/R5/R8/R9/R10/R11 random");
    end
    @(negedge clk); rst_n = 0;
    drive(2, 2, 1, 1, 1, 2, 1, 1, 2, 1, 1); cmp("R1 reset reasserted");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule